// File: doc/BRIEF.md
# Toggle-Handshake Pointer Crossing

This block moves a small pointer, such as the read index of a dual-clock queue, from the source clock domain into the destination clock domain. The two clocks may be unrelated. The multi-bit value never passes through synchronizer flops. Instead, the source side takes a snapshot of the live pointer into a holding register and announces it by inverting a single request bit. The destination side detects that inversion after the request has crossed a chain of synchronizer flops. It then copies the holding register, which is known to be stable at that point, and replies by inverting an acknowledge bit that crosses back the same way.

Each side compares the synchronized level of the peer's toggle with the level it last recorded. Any difference counts as exactly one event. The source keeps a pending flag, so it takes a new snapshot only while idle or once the acknowledge for the previous snapshot has come back. The destination view is therefore always a whole value that the pointer actually held, and it trails the live pointer by the handshake latency.

Top module: `ptr_toggle_xfer`

## Requirements
- R1: While both resets are active, the source holding register loads the live pointer and the destination view loads the holding register. After both resets are released with the pointer unchanged, `dst_ptr` equals the pointer value present during reset, and no transfer is started.
- R2: A single change of `src_ptr`, made while the crossing is idle, produces exactly one update of `dst_ptr` and no further updates afterwards.
- R3: While a snapshot is in flight (pending, with the acknowledge not yet returned), the holding register stays unchanged. A further change of `src_ptr` in that window is deferred and is not lost.
- R4: When idle, a `src_ptr` value that differs from the held copy is taken as a snapshot on the next `src_clk` rising edge, and the request toggle inverts on that same edge.
- R5: On a detected request event, the destination captures the held copy and inverts its acknowledge. A later change made after the crossing has gone idle again is again accepted with the idle latency of R6.
- R6: Each toggle crosses through `SYNC_STAGES` (default 2) flops clocked by the receiving domain. From an idle state, `dst_ptr` takes the new value on the (`SYNC_STAGES`+1)-th `dst_clk` rising edge after the snapshot edge.
- R7: `dst_ptr` only ever shows values that `src_ptr` held, in the order they were held: it may skip values but never goes back and never shows a mix of bits from two values.
- R8: Once `src_ptr` stops changing, `dst_ptr` becomes equal to it within 60 `src_clk` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain synchronous reset, active high |
| src_ptr | input | PTR_W | Live pointer in the source domain |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain synchronous reset, active high |
| dst_ptr | output | PTR_W | Pointer as seen in the destination domain |

## Verification
Starting from idle, a pointer change set up before a `src_clk` rising edge becomes a snapshot on that edge. It then shows on `dst_ptr` on exactly the third `dst_clk` rising edge that follows, with two synchronizer flops plus the capture flop. The bench counts destination edges from the snapshot edge and samples one nanosecond after each edge. The clock phases are offset so that edges of the two domains never coincide. During free-running random stepping the exact cycle is not fixed, so a scoreboard queue of every driven value checks the order and integrity of each observed change. Convergence is checked after a quiet window of 60 source cycles.

// File: rtl/ptr_xfer_pkg.sv
package ptr_xfer_pkg;
   parameter int unsigned PX_DEF_PTR_W  = 4;
   parameter int unsigned PX_DEF_STAGES = 2;

   // a difference between the live peer level and the remembered one is one event
   function automatic logic px_event(input logic now_lvl, input logic last_lvl);
      return now_lvl ^ last_lvl;
   endfunction
endpackage

// File: rtl/px_sync.sv
module px_sync #(
   parameter int unsigned STAGES  = ptr_xfer_pkg::PX_DEF_STAGES,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_depth
      $error("px_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic q_r;
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) q_r <= RST_VAL;
            else     q_r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) q_r <= RST_VAL;
            else     q_r <= g_stage[i-1].q_r;
         end
      end
   end

   assign q = g_stage[LAST].q_r;
endmodule

// File: rtl/px_src.sv
module px_src #(
   parameter int unsigned PTR_W  = ptr_xfer_pkg::PX_DEF_PTR_W,
   parameter int unsigned STAGES = ptr_xfer_pkg::PX_DEF_STAGES
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PTR_W-1:0] ptr_i,
   input  logic             ack_tgl_i,
   output logic [PTR_W-1:0] hold_o,
   output logic             req_tgl_o
);
   import ptr_xfer_pkg::*;

   logic             ack_sync;
   logic             ack_seen;
   logic             pend;
   logic [PTR_W-1:0] hold_r;
   logic             req_r;
   logic             take;

   px_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_ack_sync (
      .clk (clk),
      .rst (rst),
      .d   (ack_tgl_i),
      .q   (ack_sync)
   );

   assign take = (ptr_i != hold_r) && (!pend || px_event(ack_sync, ack_seen));

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_r   <= ptr_i;
         pend     <= 1'b0;
         req_r    <= 1'b0;
         ack_seen <= ack_sync;
      end else if (take) begin
         hold_r   <= ptr_i;
         ack_seen <= ack_sync;
         pend     <= 1'b1;
         req_r    <= ~req_r;
      end
   end

   assign hold_o    = hold_r;
   assign req_tgl_o = req_r;

   AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
      (pend && ack_sync == ack_seen) |=> $stable(hold_r)); // R3

   AST_SNAP_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
      !$stable(hold_r) |-> !$stable(req_r)); // R4

   AST_IDLE_SNAP: assert property (@(posedge clk) disable iff (rst)
      (!pend && ptr_i != hold_r) |=> (hold_r == $past(ptr_i) && pend)); // R4
endmodule

// File: rtl/px_dst.sv
module px_dst #(
   parameter int unsigned PTR_W  = ptr_xfer_pkg::PX_DEF_PTR_W,
   parameter int unsigned STAGES = ptr_xfer_pkg::PX_DEF_STAGES
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PTR_W-1:0] hold_i,
   input  logic             req_tgl_i,
   output logic [PTR_W-1:0] view_o,
   output logic             ack_tgl_o
);
   import ptr_xfer_pkg::*;

   logic             req_sync;
   logic             req_seen;
   logic             ack_r;
   logic [PTR_W-1:0] view_r;

   px_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_req_sync (
      .clk (clk),
      .rst (rst),
      .d   (req_tgl_i),
      .q   (req_sync)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         view_r   <= hold_i;
         ack_r    <= 1'b0;
         req_seen <= req_sync;
      end else if (px_event(req_sync, req_seen)) begin
         view_r   <= hold_i;
         req_seen <= req_sync;
         ack_r    <= ~ack_r;
      end
   end

   assign view_o    = view_r;
   assign ack_tgl_o = ack_r;

   AST_VIEW_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
      !$stable(view_r) |-> !$stable(ack_r)); // R5

   AST_ONE_ACK_PER_REQ: assert property (@(posedge clk) disable iff (rst)
      !$stable(ack_r) |=> $stable(ack_r)); // R2
endmodule

// File: rtl/ptr_toggle_xfer.sv
module ptr_toggle_xfer #(
   parameter int unsigned PTR_W       = ptr_xfer_pkg::PX_DEF_PTR_W,
   parameter int unsigned SYNC_STAGES = ptr_xfer_pkg::PX_DEF_STAGES
) (
   input  logic             src_clk,
   input  logic             src_rst,
   input  logic [PTR_W-1:0] src_ptr,
   input  logic             dst_clk,
   input  logic             dst_rst,
   output logic [PTR_W-1:0] dst_ptr
);
   if (PTR_W < 1) begin : g_bad_width
      $error("ptr_toggle_xfer: PTR_W must be at least 1");
   end

   logic [PTR_W-1:0] hold;
   logic             req_tgl;
   logic             ack_tgl;

   px_src #(.PTR_W(PTR_W), .STAGES(SYNC_STAGES)) u_src (
      .clk       (src_clk),
      .rst       (src_rst),
      .ptr_i     (src_ptr),
      .ack_tgl_i (ack_tgl),
      .hold_o    (hold),
      .req_tgl_o (req_tgl)
   );

   px_dst #(.PTR_W(PTR_W), .STAGES(SYNC_STAGES)) u_dst (
      .clk       (dst_clk),
      .rst       (dst_rst),
      .hold_i    (hold),
      .req_tgl_i (req_tgl),
      .view_o    (dst_ptr),
      .ack_tgl_o (ack_tgl)
   );
endmodule

// File: tb/ptr_toggle_xfer_tb.sv
`timescale 1ns/10ps
module ptr_toggle_xfer_tb;
   localparam real SRC_PERIOD = 10.0;
   localparam real DST_PERIOD = 7.3;
   localparam int  PW         = 4;
   localparam int  LAT        = 3; // SYNC_STAGES + capture flop

   logic          src_clk, src_rst, dst_clk, dst_rst;
   logic [PW-1:0] src_ptr, dst_ptr;

   int compared   = 0;
   int mismatched = 0;
   int exp_q[$];
   bit mon_on = 0;
   bit done   = 0;

   ptr_toggle_xfer #(.PTR_W(PW), .SYNC_STAGES(2)) u_dut (
      .src_clk (src_clk), .src_rst (src_rst), .src_ptr (src_ptr),
      .dst_clk (dst_clk), .dst_rst (dst_rst), .dst_ptr (dst_ptr)
   );

   initial begin src_clk = 0; forever #(SRC_PERIOD/2) src_clk = ~src_clk; end
   initial begin dst_clk = 0; #0.13; forever #(DST_PERIOD/2) dst_clk = ~dst_clk; end

   task automatic check(input string req, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   // driver: apply a new pointer value and record it for the scoreboard
   task automatic drive(input logic [PW-1:0] v);
      @(negedge src_clk);
      src_ptr = v;
      exp_q.push_back(int'(v));
   endtask

   // step from idle and count destination edges until the view moves (R4 R6)
   task automatic timed_step(input string req);
      int n = 0;
      logic [PW-1:0] nv = src_ptr + 1'b1;
      drive(nv);
      @(posedge src_clk);
      while (n < 12) begin
         @(posedge dst_clk); #1; n++;
         if (dst_ptr == nv) break;
      end
      check({req, " latency"}, n, LAT);
      check({req, " value"}, int'(dst_ptr), int'(nv));
   endtask

   // monitor: each view change must match the next driven value in order (R7)
   initial begin
      logic [PW-1:0] last;
      wait (mon_on);
      last = dst_ptr;
      forever begin
         @(posedge dst_clk); #1;
         if (dst_ptr != last) begin
            int head = (exp_q.size() > 0) ? exp_q[0] : -1;
            while (exp_q.size() > 0 && exp_q[0] != int'(dst_ptr)) void'(exp_q.pop_front());
            compared++;
            if (exp_q.size() == 0) begin
               mismatched++;
               $display("FAIL R7: actual %0d expected %0d or a later driven value", dst_ptr, head);
            end
            last = dst_ptr;
         end
      end
   end

   initial begin
      #1500000;
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      src_rst = 1; dst_rst = 1; src_ptr = 4'd5;
      exp_q.push_back(5);
      repeat (6) @(posedge src_clk);
      @(negedge src_clk); src_rst = 0;
      @(negedge dst_clk); dst_rst = 0;
      repeat (4) @(posedge dst_clk);
      #1;
      check("R1 reset view", int'(dst_ptr), 5);
      mon_on = 1;
      repeat (20) @(posedge src_clk);
      #1;
      check("R1 no spurious transfer", int'(dst_ptr), 5);

      // single steps from idle
      timed_step("R4 R6 first step");
      repeat (30) @(posedge dst_clk);
      #1;
      check("R2 single update", int'(dst_ptr), 6);
      repeat (20) @(posedge src_clk);
      timed_step("R5 second step after idle");
      repeat (40) @(posedge src_clk);

      // back-to-back change while first is in flight
      drive(src_ptr + 1'b1);
      drive(src_ptr + 1'b1);
      repeat (60) @(posedge src_clk);
      #1;
      check("R3 deferred change kept", int'(dst_ptr), int'(src_ptr));

      // random stepping, then stop
      for (int k = 0; k < 3000; k++) begin
         if (($urandom % 3) != 0) drive(src_ptr + 1'b1);
         else @(negedge src_clk);
      end
      repeat (60) @(posedge src_clk);
      #1;
      check("R8 converge random", int'(dst_ptr), int'(src_ptr));

      // every-cycle stepping, then stop
      for (int k = 0; k < 500; k++) drive(src_ptr + 1'b1);
      repeat (60) @(posedge src_clk);
      #1;
      check("R8 converge burst", int'(dst_ptr), int'(src_ptr));

      repeat (20) @(posedge src_clk);
      timed_step("R6 step after burst");

      done = 1;
      summary();
      $finish;
   end
endmodule